// File: doc/BRIEF.md
# SPI Master Transmitter with Deferred Disable

This block is the transmit half of a four-wire SPI master. Software-side logic hands it one byte at a time through a single-entry holding buffer. A shift register sends each byte on a serial data line, alongside a serial clock divided down from the system clock. An enable input decides whether held bytes may start. Clearing the enable is not abrupt: the byte in flight and any byte already held are still sent, and only then does the transmitter settle in its disabled state. A byte written while disabled waits in the buffer. It goes out as soon as the enable returns and the shifter is free.

An active-low bus-claim input lets another master take the bus. While it is low, the clock and data outputs lose their output enables and all internal progress is frozen. When the claim is released, the interrupted byte carries on from the same bit. A buffer-empty flag tells the producer when the next byte may be written.

Top module: `spi_txe_master`

## Requirements
- R1: After power-up reset (`rst_n` low) or a one-cycle soft reset (`soft_rst` high), the transmitter is disabled and the buffer is empty (`txbuf_empty` = 1). A byte written before a soft reset is discarded and is never sent.
- R2: While enabled and idle, a buffer write starts a character on the serial lines. With no write, the serial clock produces no rising edge.
- R3: Clearing `tx_en` while a character is in flight does not abort it. That character and a byte already held in the buffer are both sent, in write order.
- R4: Once the transmitter has drained and become disabled, a buffer write is held and not shifted out while `tx_en` stays 0. `txbuf_empty` stays 0.
- R5: When `tx_en` is set while disabled with a byte held, the shifter loads it on the next clock edge. The first rising serial-clock edge is seen HALF_DIV+1 cycles after `tx_en` is driven.
- R6: Characters are 8 bits, sent MSB first. Each serial-clock half period lasts HALF_DIV system cycles. `sclk_o` rests low between characters. `mosi_o` changes only on falling serial-clock edges, so it is stable at every rising edge.
- R7: While `bus_claim_n` is 0, `sclk_oe` and `mosi_oe` are 0 and the serial outputs do not change. After release, the interrupted character completes with the correct data.
- R8: `txbuf_empty` is 1 after reset. It goes to 0 the cycle after a write and returns to 1 when the held byte moves into the shifter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| tx_en | input | 1 | Transmit enable |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Byte to write |
| bus_claim_n | input | 1 | Low when another master claims the bus |
| sclk_o | output | 1 | Serial clock, idle low |
| sclk_oe | output | 1 | Output enable for the serial clock |
| mosi_o | output | 1 | Serial data, MSB first |
| mosi_oe | output | 1 | Output enable for the serial data |
| txbuf_empty | output | 1 | Holding buffer is free |
| tx_active | output | 1 | A character is being shifted |

## Verification
The bench builds the block with DATA_W = 8 and HALF_DIV = 2, so each character takes 32 system cycles. With characters this short, the drain-after-disable sequence, a long bus claim in the middle of a character, and a re-enable with a held byte all fit in a few hundred cycles. A divisor above 1 keeps a counter inside each serial-clock half period. This makes the exact HALF_DIV+1 start latency after re-enable a meaningful check, and lets the bench confirm that a bus claim freezes the divider part-way through a half period.

// File: rtl/spi_txe_pkg.sv
package spi_txe_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_IRQ   = 2'd3
    } txe_state_e;
endpackage

// File: rtl/spi_txe_ctrl.sv
module spi_txe_ctrl
    import spi_txe_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tx_en,
    input  logic              hold,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              char_done,
    output logic              load,
    output logic [DATA_W-1:0] load_data,
    output txe_state_e        state,
    output logic              buf_empty
);
    typedef struct packed {
        txe_state_e        st;
        logic [DATA_W-1:0] data;
        logic              full;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        load   = 1'b0;
        if (!hold) begin
            unique case (ctrl_q.st)
                ST_OFF: begin
                    if (tx_en) begin
                        if (ctrl_q.full) begin
                            load      = 1'b1;
                            ctrl_d.st = ST_SHIFT;
                        end else begin
                            ctrl_d.st = ST_IDLE;
                        end
                    end
                end
                ST_IDLE: begin
                    if (!tx_en) begin
                        ctrl_d.st = ST_OFF;
                    end else if (ctrl_q.full) begin
                        load      = 1'b1;
                        ctrl_d.st = ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (char_done) begin
                        ctrl_d.st = ST_IRQ;
                    end
                end
                ST_IRQ: begin
                    if (ctrl_q.full) begin
                        load      = 1'b1;
                        ctrl_d.st = ST_SHIFT;
                    end else if (tx_en) begin
                        ctrl_d.st = ST_IDLE;
                    end else begin
                        ctrl_d.st = ST_OFF;
                    end
                end
                default: ctrl_d.st = ST_OFF;
            endcase
        end
        if (load) begin
            ctrl_d.full = 1'b0;
        end
        if (wr_valid) begin
            ctrl_d.data = wr_data;
            ctrl_d.full = 1'b1;
        end
        if (soft_rst) begin
            load        = 1'b0;
            ctrl_d.st   = ST_OFF;
            ctrl_d.data = '0;
            ctrl_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.st   <= ST_OFF;
            ctrl_q.data <= '0;
            ctrl_q.full <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign load_data = ctrl_q.data;
    assign state     = ctrl_q.st;
    assign buf_empty = !ctrl_q.full;
endmodule

// File: rtl/spi_txe_sclk.sv
module spi_txe_sclk #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic phase,
    output logic fall_tick
);
    localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } div_t;

    div_t div_d, div_q;
    logic half_end;

    generate
        if (HALF_DIV == 1) begin : g_no_count
            assign half_end = 1'b1;
        end else begin : g_count
            assign half_end = (div_q.cnt == CNT_W'(HALF_DIV - 1));
        end
    endgenerate

    always_comb begin
        div_d     = div_q;
        fall_tick = run && div_q.phase && half_end;
        if (run) begin
            if (half_end) begin
                div_d.cnt   = '0;
                div_d.phase = !div_q.phase;
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
        if (clear) begin
            div_d.cnt   = '0;
            div_d.phase = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q.cnt   <= '0;
            div_q.phase <= 1'b0;
        end else begin
            div_q <= div_d;
        end
    end

    assign phase = div_q.phase;
endmodule

// File: rtl/spi_txe_shifter.sv
module spi_txe_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              mosi,
    output logic              last
);
    localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [BIT_W-1:0]  bitc;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        last  = (shf_q.bitc == BIT_W'(DATA_W - 1));
        if (load) begin
            shf_d.data = load_data;
            shf_d.bitc = '0;
        end else if (shift && !last) begin
            shf_d.data = {shf_q.data[DATA_W-2:0], 1'b0};
            shf_d.bitc = shf_q.bitc + 1'b1;
        end
        if (clear) begin
            shf_d.data = '0;
            shf_d.bitc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q.data <= '0;
            shf_q.bitc <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign mosi = shf_q.data[DATA_W-1];
endmodule

// File: rtl/spi_txe_master.sv
module spi_txe_master
    import spi_txe_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bus_claim_n,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    output logic              txbuf_empty,
    output logic              tx_active
);
    txe_state_e        state;
    logic              hold;
    logic              load;
    logic [DATA_W-1:0] load_data;
    logic              phase;
    logic              fall_tick;
    logic              last;
    logic              shifting;

    assign hold     = !bus_claim_n;
    assign shifting = (state == ST_SHIFT);

    spi_txe_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .tx_en     (tx_en),
        .hold      (hold),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .char_done (fall_tick && last),
        .load      (load),
        .load_data (load_data),
        .state     (state),
        .buf_empty (txbuf_empty)
    );

    spi_txe_sclk #(.HALF_DIV(HALF_DIV)) sclk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (load || soft_rst),
        .run       (shifting && !hold),
        .phase     (phase),
        .fall_tick (fall_tick)
    );

    spi_txe_shifter #(.DATA_W(DATA_W)) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (soft_rst),
        .load      (load),
        .load_data (load_data),
        .shift     (fall_tick),
        .mosi      (mosi_o),
        .last      (last)
    );

    assign sclk_o    = shifting && phase;
    assign sclk_oe   = bus_claim_n;
    assign mosi_oe   = bus_claim_n;
    assign tx_active = shifting;
endmodule

// File: rtl/spi_txe_chk.sv
module spi_txe_chk
    import spi_txe_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       tx_en,
    input logic       wr_valid,
    input logic       bus_claim_n,
    input logic       sclk_o,
    input logic       mosi_o,
    input logic       txbuf_empty,
    input txe_state_e st
);
    AST_SOFT_RESET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st == ST_OFF) && txbuf_empty); // R1

    AST_SHIFT_NOT_ABORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT) && !soft_rst |=> (st == ST_SHIFT) || (st == ST_IRQ)); // R3

    AST_OFF_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF) && !tx_en && !soft_rst |=> (st == ST_OFF)); // R4

    AST_PENDING_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF) && tx_en && !txbuf_empty && bus_claim_n && !soft_rst
        |=> (st == ST_SHIFT)); // R5

    AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(mosi_o)); // R6

    AST_CLAIM_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_claim_n && !soft_rst |=> $stable(sclk_o) && $stable(mosi_o)); // R7

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !soft_rst |=> !txbuf_empty); // R8
endmodule

bind spi_txe_master spi_txe_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .tx_en       (tx_en),
    .wr_valid    (wr_valid),
    .bus_claim_n (bus_claim_n),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .txbuf_empty (txbuf_empty),
    .st          (state)
);

// File: tb/spi_txe_master_tb_top.sv
module spi_txe_master_tb_top;
    localparam int unsigned DW = 8;
    localparam int unsigned HD = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          tx_en = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          bus_claim_n = 1'b1;
    logic          sclk_o, sclk_oe, mosi_o, mosi_oe, txbuf_empty, tx_active;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    spi_txe_master #(.DATA_W(DW), .HALF_DIV(HD)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .tx_en       (tx_en),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .bus_claim_n (bus_claim_n),
        .sclk_o      (sclk_o),
        .sclk_oe     (sclk_oe),
        .mosi_o      (mosi_o),
        .mosi_oe     (mosi_oe),
        .txbuf_empty (txbuf_empty),
        .tx_active   (tx_active)
    );

    // serial receiver model: samples data on every rising serial-clock edge
    int          rise_cnt = 0;
    int          rx_cnt   = 0;
    int          bit_n    = 0;
    logic [7:0]  rx_sh    = '0;
    logic [7:0]  rx_log [16];
    logic        sclk_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk_o && !sclk_prev) begin
                rise_cnt = rise_cnt + 1;
                rx_sh    = {rx_sh[6:0], mosi_o};
                bit_n    = bit_n + 1;
                if (bit_n == 8) begin
                    if (rx_cnt < 16) rx_log[rx_cnt] = rx_sh;
                    rx_cnt = rx_cnt + 1;
                    bit_n  = 0;
                end
            end
            sclk_prev = sclk_o;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk(txbuf_empty == 1'b1, "R1 empty after reset", txbuf_empty, 1);
        chk(sclk_o == 1'b0, "R6 sclk idle low", sclk_o, 0);
        chk(tx_active == 1'b0, "R1 inactive after reset", tx_active, 0);
        chk(sclk_oe && mosi_oe, "R7 outputs driven with bus free", {sclk_oe, mosi_oe}, 3);
    endtask

    task automatic t_idle_no_write;
        int r0;
        tx_en = 1'b1;
        r0 = rise_cnt;
        cyc(40);
        chk(rise_cnt == r0, "R2 no clock without write", rise_cnt, r0);
    endtask

    task automatic t_single;
        int k;
        k = rx_cnt;
        write_byte(8'hA5);
        chk(txbuf_empty == 1'b0, "R8 write clears empty", txbuf_empty, 0);
        cyc(1);
        chk(txbuf_empty == 1'b1, "R8 empty on move to shifter", txbuf_empty, 1);
        chk(tx_active == 1'b1, "R2 transmission started", tx_active, 1);
        cyc(60);
        chk(rx_cnt == k + 1, "R2 one character sent", rx_cnt, k + 1);
        chk(rx_log[k] == 8'hA5, "R6 MSB-first byte", rx_log[k], 8'hA5);
        chk(sclk_o == 1'b0, "R6 sclk low after character", sclk_o, 0);
    endtask

    task automatic t_back_to_back;
        int k;
        k = rx_cnt;
        write_byte(8'h3C);
        cyc(3);
        write_byte(8'hC3);
        chk(txbuf_empty == 1'b0, "R8 second byte held", txbuf_empty, 0);
        cyc(100);
        chk(rx_cnt == k + 2, "R2 two characters sent", rx_cnt, k + 2);
        chk(rx_log[k] == 8'h3C, "R6 first byte", rx_log[k], 8'h3C);
        chk(rx_log[k+1] == 8'hC3, "R6 second byte", rx_log[k+1], 8'hC3);
    endtask

    task automatic t_drain;
        int k;
        k = rx_cnt;
        write_byte(8'h11);
        cyc(3);
        write_byte(8'h22);
        tx_en = 1'b0;
        cyc(120);
        chk(rx_cnt == k + 2, "R3 drain sends both", rx_cnt, k + 2);
        chk(rx_log[k] == 8'h11, "R3 in-flight byte", rx_log[k], 8'h11);
        chk(rx_log[k+1] == 8'h22, "R3 held byte", rx_log[k+1], 8'h22);
        chk(tx_active == 1'b0, "R3 stopped after drain", tx_active, 0);
    endtask

    task automatic t_disabled_hold;
        int r0;
        r0 = rise_cnt;
        write_byte(8'h5A);
        cyc(80);
        chk(rise_cnt == r0, "R4 no shifting while disabled", rise_cnt, r0);
        chk(txbuf_empty == 1'b0, "R4 byte stays held", txbuf_empty, 0);
    endtask

    task automatic t_reenable;
        int k;
        int n;
        k = rx_cnt;
        n = 0;
        @(negedge clk);
        tx_en = 1'b1;
        while (!sclk_o && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(n == HD + 1, "R5 start latency", n, HD + 1);
        cyc(60);
        chk(rx_cnt == k + 1 && rx_log[k] == 8'h5A, "R5 pending byte sent", rx_log[k], 8'h5A);
    endtask

    task automatic t_claim;
        int k;
        int r0;
        logic s0, m0;
        k = rx_cnt;
        write_byte(8'h96);
        cyc(11);
        bus_claim_n = 1'b0;
        @(negedge clk);
        chk(!sclk_oe && !mosi_oe, "R7 outputs released", {sclk_oe, mosi_oe}, 0);
        r0 = rise_cnt;
        s0 = sclk_o;
        m0 = mosi_o;
        cyc(50);
        chk(rise_cnt == r0, "R7 no clock while claimed", rise_cnt, r0);
        chk(sclk_o == s0 && mosi_o == m0, "R7 outputs frozen", {sclk_o, mosi_o}, {s0, m0});
        chk(tx_active == 1'b1, "R7 character held", tx_active, 1);
        bus_claim_n = 1'b1;
        cyc(80);
        chk(rx_cnt == k + 1 && rx_log[k] == 8'h96, "R7 resumed byte", rx_log[k], 8'h96);
    endtask

    task automatic t_soft_reset;
        int r0;
        tx_en = 1'b0;
        cyc(5);
        write_byte(8'h77);
        chk(txbuf_empty == 1'b0, "R1 byte held before soft reset", txbuf_empty, 0);
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk(txbuf_empty == 1'b1, "R1 soft reset empties buffer", txbuf_empty, 1);
        r0 = rise_cnt;
        tx_en = 1'b1;
        cyc(60);
        chk(rise_cnt == r0, "R1 discarded byte not sent", rise_cnt, r0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_idle_no_write();
        t_single();
        t_back_to_back();
        t_drain();
        t_disabled_hold();
        t_reenable();
        t_claim();
        t_soft_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule